// File: doc/BRIEF.md
# Parallel Display Bus Strobe Timer

This block drives the control strobes of an 8080-style parallel bus that connects a host to a display controller with its own frame memory. One request arrives at a time over a ready/valid handshake: a command write, a data (parameter or pixel) write, or a read. Each accepted request becomes one bus access. The access is measured in ticks. A tick is one clock long, or two clocks long when the tick-length bit is set. The start and end tick of every strobe come from two packed 32-bit timing words.

During an access the block asserts chip select, write enable and read enable inside their own tick windows. It also holds the command/data select line at the level that matches the request. On writes it drives the data bus. On reads it releases the bus and samples it at the programmed access tick. The access ends when its cycle length has elapsed. The block then raises a one-clock completion pulse and, for a read, presents the sampled word. Software sets the timing words, the polarity bits and the chip-select choice as plain configuration inputs. The timing words, the tick length and the chip-select choice are captured when a request is accepted. The polarity bits act continuously.

Timing word 0 field positions: CS on [3:0], CS off [9:4], WE on [13:10], WE off [19:14], RE on [23:20], RE off [29:24]. Timing word 1 field positions: write cycle length [5:0], read cycle length [11:6], CS pulse width [17:12] (accepted, not used for timing), access tick [27:22]. A correct setup has WE off > WE on, RE off > RE on, CS off > CS on, CS off >= max(WE off, RE off), write length >= WE off, read length >= RE off, and access tick > RE on.

Top module: `pbus_strobe_timer`

## Requirements
- R1: While reset is high and in the first idle clock after it, with all polarity bits 0, the outputs are: req_ready 1, done 0, rd_data 0, bus_d_oe 0, every bus_cs_o bit 1, bus_we_o 1, bus_re_o 1 and bus_a0_o 1.
- R2: Tick 0 of an access starts in the clock that follows the accepting edge. A tick lasts 1 clock when cfg_tick2 is 0 and 2 clocks when it is 1. Chip select is active during exactly the ticks t where CS on <= t < CS off.
- R3: On a write (req_kind 0 or 1), write enable is active during exactly the ticks WE on <= t < WE off, and read enable stays inactive. bus_d_oe is 1 and bus_d_o carries the accepted req_wdata for the whole access.
- R4: On a read (req_kind 2 or 3), read enable is active during exactly the ticks RE on <= t < RE off, write enable stays inactive, and bus_d_oe is 0.
- R5: bus_a0_o is at the command level (0 with default polarity) during an access of req_kind 0. It is at the data level (1) during every other access and while idle.
- R6: An access lasts the write cycle length in ticks for writes and the read cycle length in ticks for reads. req_ready is 0 from the accepting edge until the access ends, so requests presented meanwhile are ignored. In the clock after the last tick, done is 1 for one clock, req_ready is 1, and a request accepted in that clock starts the next access at once.
- R7: A read samples bus_d_i on the clock edge that ends the first clock of tick "access tick". rd_data takes that value in the clock where done is 1. Writes leave rd_data unchanged.
- R8: With its polarity bit at 1, each of chip select, write enable, read enable and command/data select is inverted. At 0, chip select, write enable and read enable are active low.
- R9: cfg_cs_sel value 1 drives bus_cs_o[0], value 2 drives bus_cs_o[1], and values 0 and 3 drive no chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_time0 | input | 32 | Strobe on/off ticks for CS, WE and RE |
| cfg_time1 | input | 32 | Cycle lengths, CS pulse width and access tick |
| cfg_tick2 | input | 1 | 0: one clock per tick, 1: two clocks per tick |
| cfg_cs_sel | input | SEL_W (2) | Chip-select choice: 1 is CS0, 2 is CS1 |
| cfg_cs_inv | input | 1 | Invert chip-select outputs |
| cfg_we_inv | input | 1 | Invert write enable |
| cfg_re_inv | input | 1 | Invert read enable |
| cfg_a0_inv | input | 1 | Invert command/data select |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 command write, 1 data write, 2 or 3 read |
| req_wdata | input | DATA_W (16) | Write word |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W (16) | Word sampled by the last read |
| bus_cs_o | output | NUM_CS (2) | Chip-select strobes |
| bus_we_o | output | 1 | Write-enable strobe |
| bus_re_o | output | 1 | Read-enable strobe |
| bus_a0_o | output | 1 | Command/data select |
| bus_d_o | output | DATA_W (16) | Data bus out |
| bus_d_oe | output | 1 | Data bus output enable |
| bus_d_i | input | DATA_W (16) | Data bus in |

## Verification
The bench builds the block with DATA_W = 16 and NUM_CS = 2. Two chip selects let every 2-bit select code be exercised, including the two codes that select neither output. The 16-bit bus lets the bench drive a different word in every clock of a read. The sampled word therefore shows the exact clock of capture, under both tick lengths and when the access tick is the final tick of the access.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int ON_W  = 4;   // width of an assert-tick field
  localparam int TCK_W = 6;   // width of deassert, length and access fields

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [TCK_W-1:0] cs_off;
    logic [ON_W-1:0]  we_on;
    logic [TCK_W-1:0] we_off;
    logic [ON_W-1:0]  re_on;
    logic [TCK_W-1:0] re_off;
    logic [TCK_W-1:0] wr_len;
    logic [TCK_W-1:0] rd_len;
    logic [TCK_W-1:0] acc_at;
  } timing_t;

  function automatic timing_t unpack_timing(input logic [31:0] w0,
                                            input logic [31:0] w1);
    timing_t t;
    t.cs_on  = w0[3:0];
    t.cs_off = w0[9:4];
    t.we_on  = w0[13:10];
    t.we_off = w0[19:14];
    t.re_on  = w0[23:20];
    t.re_off = w0[29:24];
    t.wr_len = w1[5:0];
    t.rd_len = w1[11:6];
    t.acc_at = w1[27:22];
    return t;
  endfunction

  // True when tick lies in the half-open window [lo, hi)
  function automatic logic in_window(input logic [TCK_W-1:0] tick,
                                     input logic [ON_W-1:0]  lo,
                                     input logic [TCK_W-1:0] hi);
    return (tick >= {{(TCK_W-ON_W){1'b0}}, lo}) && (tick < hi);
  endfunction

endpackage

// File: rtl/pbus_tick_gen.sv
module pbus_tick_gen #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick2,
  input  logic [CNT_W-1:0] cyc_len,
  output logic             busy_q,
  output logic             busy_n,
  output logic [CNT_W-1:0] tick_q,
  output logic [CNT_W-1:0] tick_n,
  output logic             sub_q,
  output logic             end_acc,
  output logic             done_q
);

  logic             sub_n;
  logic             last_sub;
  logic [CNT_W:0]   tick_inc;

  assign last_sub = !tick2 || sub_q;
  assign tick_inc = {1'b0, tick_q} + 1'b1;
  assign end_acc  = busy_q && last_sub && (tick_inc >= {1'b0, cyc_len});

  always_comb begin
    busy_n = busy_q;
    tick_n = tick_q;
    sub_n  = 1'b0;
    if (start) begin
      busy_n = 1'b1;
      tick_n = '0;
    end else if (busy_q) begin
      if (!last_sub) begin
        sub_n = 1'b1;
      end else if (end_acc) begin
        busy_n = 1'b0;
      end else begin
        tick_n = tick_inc[CNT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tick_q <= '0;
      sub_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      tick_q <= tick_n;
      sub_q  <= sub_n;
      done_q <= end_acc;
    end
  end

endmodule

// File: rtl/pbus_strobe_gen.sv
module pbus_strobe_gen
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              act,
  input  logic [TCK_W-1:0]  tick,
  input  timing_t           tm,
  input  logic              is_rd,
  input  logic              is_cmd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [SEL_W-1:0]  cs_sel,
  input  logic              cs_inv,
  input  logic              we_inv,
  input  logic              re_inv,
  input  logic              a0_inv,
  output logic [NUM_CS-1:0] cs_o,
  output logic              we_o,
  output logic              re_o,
  output logic              a0_o,
  output logic [DATA_W-1:0] d_o,
  output logic              d_oe
);

  logic              cs_win, we_win, re_win;
  logic [NUM_CS-1:0] cs_next;

  assign cs_win = act && in_window(tick, tm.cs_on, tm.cs_off);
  assign we_win = act && !is_rd && in_window(tick, tm.we_on, tm.we_off);
  assign re_win = act &&  is_rd && in_window(tick, tm.re_on, tm.re_off);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_next[i] = ~(cs_win && (cs_sel == SEL_W'(i + 1))) ^ cs_inv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_o <= '1;
      we_o <= 1'b1;
      re_o <= 1'b1;
      a0_o <= 1'b1;
      d_o  <= '0;
      d_oe <= 1'b0;
    end else begin
      cs_o <= cs_next;
      we_o <= ~we_win ^ we_inv;
      re_o <= ~re_win ^ re_inv;
      a0_o <= ~(act && is_cmd) ^ a0_inv;
      d_oe <= act && !is_rd;
      if (act && !is_rd) d_o <= wdata;
    end
  end

endmodule

// File: rtl/pbus_read_capture.sv
module pbus_read_capture
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_q,
  input  logic              is_rd_q,
  input  logic [TCK_W-1:0]  tick_q,
  input  logic              sub_q,
  input  logic [TCK_W-1:0]  acc_at,
  input  logic              end_acc,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] rd_data
);

  logic              hit;
  logic [DATA_W-1:0] cap_q;

  assign hit = busy_q && is_rd_q && (tick_q == acc_at) && !sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      rd_data <= '0;
    end else begin
      if (hit) cap_q <= d_i;
      if (end_acc && is_rd_q) rd_data <= hit ? d_i : cap_q;
    end
  end

endmodule

// File: rtl/pbus_strobe_timer.sv
module pbus_strobe_timer
  import pbus_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  localparam int SEL_W = $clog2(NUM_CS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [31:0]       cfg_time0,
  input  logic [31:0]       cfg_time1,
  input  logic              cfg_tick2,
  input  logic [SEL_W-1:0]  cfg_cs_sel,
  input  logic              cfg_cs_inv,
  input  logic              cfg_we_inv,
  input  logic              cfg_re_inv,
  input  logic              cfg_a0_inv,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CS-1:0] bus_cs_o,
  output logic              bus_we_o,
  output logic              bus_re_o,
  output logic              bus_a0_o,
  output logic [DATA_W-1:0] bus_d_o,
  output logic              bus_d_oe,
  input  logic [DATA_W-1:0] bus_d_i
);

  logic              busy_q, busy_n, sub_q, end_acc, start;
  logic [TCK_W-1:0]  tick_q, tick_n, cyc_len;
  timing_t           live_t, snap_t, eff_t;
  logic              snap_tick2, snap_rd, snap_cmd;
  logic [DATA_W-1:0] snap_wd;
  logic [SEL_W-1:0]  snap_sel;
  logic              unused_cfg;

  assign live_t     = unpack_timing(cfg_time0, cfg_time1);
  assign unused_cfg = ^{cfg_time0[31:30], cfg_time1[21:12], cfg_time1[31:28]};
  assign req_ready  = !busy_q;
  assign start      = req_valid && !busy_q;

  // Access settings are frozen on the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_t     <= '0;
      snap_tick2 <= 1'b0;
      snap_rd    <= 1'b0;
      snap_cmd   <= 1'b0;
      snap_wd    <= '0;
      snap_sel   <= '0;
    end else if (start) begin
      snap_t     <= live_t;
      snap_tick2 <= cfg_tick2;
      snap_rd    <= req_kind[1];
      snap_cmd   <= (req_kind == 2'd0);
      snap_wd    <= req_wdata;
      snap_sel   <= cfg_cs_sel;
    end
  end

  assign eff_t   = start ? live_t : snap_t;
  assign cyc_len = snap_rd ? snap_t.rd_len : snap_t.wr_len;

  pbus_tick_gen #(.CNT_W(TCK_W)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tick2   (snap_tick2),
    .cyc_len (cyc_len),
    .busy_q  (busy_q),
    .busy_n  (busy_n),
    .tick_q  (tick_q),
    .tick_n  (tick_n),
    .sub_q   (sub_q),
    .end_acc (end_acc),
    .done_q  (done)
  );

  pbus_strobe_gen #(.DATA_W(DATA_W), .NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_strobe (
    .clk    (clk),
    .rst    (rst),
    .act    (busy_n),
    .tick   (tick_n),
    .tm     (eff_t),
    .is_rd  (start ? req_kind[1] : snap_rd),
    .is_cmd (start ? (req_kind == 2'd0) : snap_cmd),
    .wdata  (start ? req_wdata : snap_wd),
    .cs_sel (start ? cfg_cs_sel : snap_sel),
    .cs_inv (cfg_cs_inv),
    .we_inv (cfg_we_inv),
    .re_inv (cfg_re_inv),
    .a0_inv (cfg_a0_inv),
    .cs_o   (bus_cs_o),
    .we_o   (bus_we_o),
    .re_o   (bus_re_o),
    .a0_o   (bus_a0_o),
    .d_o    (bus_d_o),
    .d_oe   (bus_d_oe)
  );

  pbus_read_capture #(.DATA_W(DATA_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .busy_q  (busy_q),
    .is_rd_q (snap_rd),
    .tick_q  (tick_q),
    .sub_q   (sub_q),
    .acc_at  (snap_t.acc_at),
    .end_acc (end_acc),
    .d_i     (bus_d_i),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/pbus_strobe_timer_chk.sv
module pbus_strobe_timer_chk #(
  parameter int DATA_W = 16,
  parameter int NUM_CS = 2,
  localparam int SEL_W = $clog2(NUM_CS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       cfg_time0,
  input logic [31:0]       cfg_time1,
  input logic              cfg_tick2,
  input logic [SEL_W-1:0]  cfg_cs_sel,
  input logic              cfg_cs_inv,
  input logic              cfg_we_inv,
  input logic              cfg_re_inv,
  input logic              cfg_a0_inv,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic [DATA_W-1:0] req_wdata,
  input logic              done,
  input logic [DATA_W-1:0] rd_data,
  input logic [NUM_CS-1:0] bus_cs_o,
  input logic              bus_we_o,
  input logic              bus_re_o,
  input logic              bus_a0_o,
  input logic [DATA_W-1:0] bus_d_o,
  input logic              bus_d_oe,
  input logic [DATA_W-1:0] bus_d_i
);

  logic              rst_q, cs_inv_q, we_inv_q, re_inv_q;
  logic [NUM_CS-1:0] cs_act;
  logic              we_act, re_act;

  // Outputs are registered, so they follow the polarity of the prior clock
  always_ff @(posedge clk) begin
    rst_q    <= rst;
    cs_inv_q <= cfg_cs_inv;
    we_inv_q <= cfg_we_inv;
    re_inv_q <= cfg_re_inv;
  end

  assign cs_act = ~(bus_cs_o ^ {NUM_CS{cs_inv_q}});
  assign we_act = (bus_we_o == we_inv_q);
  assign re_act = (bus_re_o == re_inv_q);

  p_done_ready_r6: assert property (@(posedge clk) disable iff (rst || rst_q)
    done |-> req_ready);
  p_done_single_r6: assert property (@(posedge clk) disable iff (rst || rst_q)
    done |=> !done);
  p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst || rst_q)
    (req_valid && req_ready) |=> !req_ready);
  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst || rst_q)
    req_ready |-> (cs_act == '0 && !we_act && !re_act && !bus_d_oe));
  p_oe_no_read_r4: assert property (@(posedge clk) disable iff (rst || rst_q)
    bus_d_oe |-> !re_act);
  p_we_re_excl_r3: assert property (@(posedge clk) disable iff (rst || rst_q)
    !(we_act && re_act));
  p_cs_single_r9: assert property (@(posedge clk) disable iff (rst || rst_q)
    $onehot0(cs_act));
  p_rd_hold_r7: assert property (@(posedge clk) disable iff (rst || rst_q)
    !$stable(rd_data) |-> done);

endmodule

bind pbus_strobe_timer pbus_strobe_timer_chk #(.DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_chk (.*);

// File: tb/pbus_strobe_timer_tb.sv
`timescale 1ns/1ps
module pbus_strobe_timer_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [31:0]   cfg_time0 = '0, cfg_time1 = '0;
  logic          cfg_tick2 = 1'b0;
  logic [1:0]    cfg_cs_sel = 2'd1;
  logic          cfg_cs_inv = 1'b0, cfg_we_inv = 1'b0, cfg_re_inv = 1'b0, cfg_a0_inv = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          done;
  logic [DW-1:0] rd_data;
  logic [1:0]    bus_cs_o;
  logic          bus_we_o, bus_re_o, bus_a0_o, bus_d_oe;
  logic [DW-1:0] bus_d_o;
  logic [DW-1:0] bus_d_i = '0;
  logic [5:0]    pins;

  always #2.5 clk = ~clk;

  pbus_strobe_timer #(.DATA_W(DW), .NUM_CS(2)) u_dut (.*);

  assign pins = {bus_cs_o, bus_we_o, bus_re_o, bus_a0_o, bus_d_oe};

  int n_chk = 0, n_err = 0;
  int cson, csoff, weon, weoff, reon, reoff, wecyc, recyc, acc, cspw;
  logic [DW-1:0] prev_rd = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    cfg_time0 = {2'b00, 6'(reoff), 4'(reon), 6'(weoff), 4'(weon), 6'(csoff), 4'(cson)};
    cfg_time1 = {4'h0, 6'(acc), 4'h0, 6'(cspw), 6'(recyc), 6'(wecyc)};
  endtask

  function automatic logic [5:0] exp_pins(input bit act, input int tk, input int kind);
    bit rd  = (kind >= 2);
    bit csa = act && tk >= cson && tk < csoff;
    bit wea = act && !rd && tk >= weon && tk < weoff;
    bit rea = act && rd && tk >= reon && tk < reoff;
    logic [1:0] csv;
    for (int i = 0; i < 2; i++) csv[i] = !(csa && int'(cfg_cs_sel) == i + 1) ^ cfg_cs_inv;
    return {csv, !wea ^ cfg_we_inv, !rea ^ cfg_re_inv,
            !(act && kind == 0) ^ cfg_a0_inv, act && !rd};
  endfunction

  // Called at a falling edge while idle; returns at the falling edge of the done clock
  task automatic run_acc(input int kind, input logic [DW-1:0] wd, input bit junk);
    int g = cfg_tick2 ? 2 : 1;
    bit rd = (kind >= 2);
    int cyc = rd ? recyc : wecyc;
    logic [DW-1:0] base = DW'($urandom);
    req_valid = 1'b1; req_kind = 2'(kind); req_wdata = wd;
    @(posedge clk);
    for (int k = 0; k <= cyc * g; k++) begin
      @(negedge clk);
      if (k == 0 && junk) begin
        req_kind = ~req_kind; req_wdata = ~wd;   // ignored while busy (R6)
      end else req_valid = 1'b0;
      bus_d_i = base + DW'(k);
      if (k < cyc * g) begin
        chk(pins == exp_pins(1'b1, k / g, kind), "R2 R3 R4 R5 R8 R9 strobes", pins, exp_pins(1'b1, k / g, kind));
        chk(!req_ready && !done, "R6 busy", {req_ready, done}, 0);
        if (!rd) chk(bus_d_o == wd, "R3 write data", bus_d_o, wd);
      end else begin
        chk(pins == exp_pins(1'b0, 0, kind), "R5 R6 idle after access", pins, exp_pins(1'b0, 0, kind));
        chk(done && req_ready, "R6 completion", {done, req_ready}, 2'b11);
        if (rd) prev_rd = base + DW'(acc * g);
        chk(rd_data == prev_rd, "R7 read data", rd_data, prev_rd);
      end
    end
  endtask

  task automatic base_cfg();
    cson = 1; csoff = 8; weon = 2; weoff = 5; reon = 1; reoff = 6;
    wecyc = 7; recyc = 9; acc = 4; cspw = 3;
    apply_cfg();
  endtask

  task automatic rand_cfg();
    cson  = $urandom % 16;  weon = $urandom % 16;  reon = $urandom % 16;
    weoff = weon + 1 + $urandom % 8;
    reoff = reon + 1 + $urandom % 8;
    csoff = cson + 1;
    if (weoff > csoff) csoff = weoff;
    if (reoff > csoff) csoff = reoff;
    csoff += $urandom % 3;
    wecyc = weoff + $urandom % 4;
    recyc = reoff + 1 + $urandom % 3;
    acc   = reon + 1 + $urandom % (recyc - reon - 1);
    cspw  = $urandom % 64;
    apply_cfg();
    cfg_tick2  = 1'($urandom);
    cfg_cs_sel = 2'($urandom);
    cfg_cs_inv = 1'($urandom); cfg_we_inv = 1'($urandom);
    cfg_re_inv = 1'($urandom); cfg_a0_inv = 1'($urandom);
  endtask

  initial begin
    #(5.0 * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'h2b5e_91c7);
    base_cfg();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(pins == 6'b111110 && req_ready && !done && rd_data == 0, "R1 reset state",
        {pins, req_ready, done}, {6'b111110, 2'b10});
    rst = 1'b0;
    @(negedge clk);
    chk(pins == 6'b111110 && req_ready && !done && rd_data == 0, "R1 idle after reset",
        {pins, req_ready, done}, {6'b111110, 2'b10});

    // R5 command vs data level, R3 writes, R4 R7 read, single-clock ticks (R2)
    run_acc(0, 16'hA5C3, 1'b0);
    run_acc(1, 16'h1234, 1'b0);
    run_acc(2, 16'h0000, 1'b0);
    // R2 two-clock ticks
    cfg_tick2 = 1'b1;
    run_acc(3, 16'h0000, 1'b0);
    run_acc(1, 16'hBEEF, 1'b0);
    cfg_tick2 = 1'b0;
    // R9 chip-select choice, including codes with no output
    cfg_cs_sel = 2'd2; run_acc(1, 16'h0F0F, 1'b0);
    cfg_cs_sel = 2'd0; run_acc(0, 16'h00FF, 1'b0);
    cfg_cs_sel = 2'd3; run_acc(2, 16'h0000, 1'b0);
    cfg_cs_sel = 2'd1;
    // R8 all outputs inverted
    cfg_cs_inv = 1'b1; cfg_we_inv = 1'b1; cfg_re_inv = 1'b1; cfg_a0_inv = 1'b1;
    @(negedge clk);
    run_acc(0, 16'h5A5A, 1'b0);
    run_acc(2, 16'h0000, 1'b0);
    cfg_cs_inv = 1'b0; cfg_we_inv = 1'b0; cfg_re_inv = 1'b0; cfg_a0_inv = 1'b0;
    @(negedge clk);
    // R7 access tick on the final tick of the read, both tick lengths
    acc = recyc - 1; apply_cfg();
    run_acc(2, 16'h0000, 1'b0);
    cfg_tick2 = 1'b1; run_acc(2, 16'h0000, 1'b0);
    cfg_tick2 = 1'b0;
    // R6 one-tick writes back to back, with requests held during busy
    cson = 0; csoff = 1; weon = 0; weoff = 1; wecyc = 1; apply_cfg();
    run_acc(0, 16'h1111, 1'b1);
    run_acc(1, 16'h2222, 1'b1);
    run_acc(0, 16'h3333, 1'b0);

    // Random configurations and request mixes
    for (int n = 0; n < 40; n++) begin
      rand_cfg();
      @(negedge clk);
      for (int j = 0; j < 4; j++)
        run_acc(int'($urandom % 4), DW'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule